// File: doc/BRIEF.md
# Packed 16-bit Subword SIMD ALU

This block treats each 64-bit operand as four separate 16-bit lanes and applies one operation to every lane at the same time. No carry or borrow passes from one lane to the next. Each lane can wrap, clamp to the signed 16-bit range, or clamp to the unsigned 16-bit range, and it does so independently of the other lanes. The operations are add, subtract, rounded average, shift-then-add with signed clamping, logical or arithmetic right shift, and left shift.

A caller presents two operands together with an opcode, a mode, a shift amount and a valid strobe. One clock edge later the result appears in a register, together with a valid flag. When valid is low, the result register keeps its last value. An opcode, mode and shift amount that do not form a legal combination still give a valid result, and that result is all zeros.

Top module: `simd16_alu`

## Requirements
- R1: Lane i occupies bits [16i+15:16i]. A modulo add wraps each lane on its own, so no carry reaches the neighbouring lane.
- R2: Add is opcode 0. Mode 0 wraps. Mode 1 clamps each lane to 0x7FFF on positive overflow and to 0x8000 on negative overflow. Mode 2 treats lanes as unsigned and clamps to 0xFFFF.
- R3: Subtract is opcode 1 and computes a minus b. Mode 0 wraps. Mode 1 clamps to the signed range. Mode 2 treats lanes as unsigned and clamps a negative difference to 0x0000.
- R4: Average is opcode 2. Each lane gives (a + b + 1) >> 1 on unsigned values, computed without overflow. The mode is ignored.
- R5: Shift-left-add is opcode 3 with a shift amount of 1 to 3. Each lane gives (a << k) + b clamped to the signed range. If a << k alone falls outside the signed range, the lane clamps toward the sign of a, whatever b is.
- R6: Shift-right-add is opcode 4 with a shift amount of 1 to 3. Each lane gives (a >>> k) + b, with sign fill, clamped to the signed range.
- R7: Right shift is opcode 5. Each lane of a shifts by the amount 0 to 15. Mode 0 fills with zeros and mode 1 fills with the sign bit.
- R8: Left shift is opcode 6. Each lane of a shifts left by the amount 0 to 15 and fills with zeros.
- R9: The result and a high out_valid appear exactly one cycle after in_valid. While in_valid is low, out_valid is low and the result holds its value.
- R10: Each of the following yields an all-zero result with out_valid high: opcode 7, add or subtract with mode 3, right shift with mode 2 or 3, and shift-add with an amount outside 1 to 3.
- R11: With rst_n low at a clock edge, the result and out_valid are cleared, even if in_valid is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid |
| op | input | 3 | Operation select |
| mode | input | 2 | Arithmetic or fill mode |
| shamt | input | 4 | Shift amount, same for all lanes |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered packed result |

## Verification
Within one operation, a single lane can clamp high while a neighbouring lane clamps low. The signed-saturating add and subtract vectors force this by placing 0x7FFF plus one and 0x8000 plus 0x8000 side by side, and every lane of the result is compared against hand-computed values. A second collision happens when reset falls in the same cycle as a valid operation. The bench drives both together and expects a zero result with out_valid low after that edge.

// File: rtl/simd16_alu.sv
module simd16_alu #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [1:0]          mode,
  input  logic [3:0]          shamt,
  input  logic [LANES*LW-1:0] a,
  input  logic [LANES*LW-1:0] b,
  output logic                out_valid,
  output logic [LANES*LW-1:0] result
);
  localparam int W = LANES * LW;
  localparam int XW = LW + 4;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AVG = 3'd2,
                         OP_SLA = 3'd3, OP_SRA = 3'd4, OP_SHR = 3'd5, OP_SHL = 3'd6;

  function automatic logic [LW-1:0] clamp_s(input logic signed [XW-1:0] v);
    logic fits;
    fits = (v[XW-1:LW-1] == '0) || (v[XW-1:LW-1] == '1);
    if (fits) clamp_s = v[LW-1:0];
    else      clamp_s = v[XW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
  endfunction

  function automatic logic [LW-1:0] lane_op(input logic [LW-1:0] x, input logic [LW-1:0] y,
                                            input logic [2:0] o, input logic [1:0] m,
                                            input logic [3:0] k);
    logic signed [XW-1:0] sx, sy, sh;
    logic [LW:0] u;
    logic amt_ok;
    sx = {{4{x[LW-1]}}, x};
    sy = {{4{y[LW-1]}}, y};
    amt_ok = (k >= 4'd1) && (k <= 4'd3);
    lane_op = '0;
    unique case (o)
      OP_ADD: begin
        u = {1'b0, x} + {1'b0, y};
        case (m)
          2'd0: lane_op = u[LW-1:0];
          2'd1: lane_op = clamp_s(sx + sy);
          2'd2: lane_op = u[LW] ? '1 : u[LW-1:0];
          default: lane_op = '0;
        endcase
      end
      OP_SUB: begin
        u = {1'b0, x} - {1'b0, y};
        case (m)
          2'd0: lane_op = u[LW-1:0];
          2'd1: lane_op = clamp_s(sx - sy);
          2'd2: lane_op = u[LW] ? '0 : u[LW-1:0];
          default: lane_op = '0;
        endcase
      end
      OP_AVG: begin
        u = {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, 1'b1};
        lane_op = u[LW:1];
      end
      OP_SLA: if (amt_ok) begin
        sh = sx <<< k;
        if ((sh[XW-1:LW-1] == '0) || (sh[XW-1:LW-1] == '1)) lane_op = clamp_s(sh + sy);
        else lane_op = x[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
      end
      OP_SRA: if (amt_ok) begin
        sh = sx >>> k;
        lane_op = clamp_s(sh + sy);
      end
      OP_SHR: begin
        if (m == 2'd0)      lane_op = x >> k;
        else if (m == 2'd1) lane_op = $signed(x) >>> k;
      end
      OP_SHL: lane_op = x << k;
      default: lane_op = '0;
    endcase
  endfunction

  logic [W-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign nxt[i*LW +: LW] = lane_op(a[i*LW +: LW], b[i*LW +: LW], op, mode, shamt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R10
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (result == '0));
  // R2
  us_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADD && mode == 2'd2) |=> (result[LW-1:0] >= $past(a[LW-1:0])));
  // R3
  us_sub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SUB && mode == 2'd2) |=> (result[LW-1:0] <= $past(a[LW-1:0])));
  // R4
  avg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_AVG) |=> (result[LW-1:0] <=
      (($past(a[LW-1:0]) > $past(b[LW-1:0])) ? $past(a[LW-1:0]) : $past(b[LW-1:0]))));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));
endmodule

// File: tb/simd16_alu_test.sv
module simd16_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] mode = '0;
  logic [3:0] shamt = '0;
  logic [63:0] a = '0, b = '0;
  logic out_valid;
  logic [63:0] result;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd16_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
                  .shamt(shamt), .a(a), .b(b), .out_valid(out_valid), .result(result));

  localparam int NV = 19;
  // {op, mode, shamt, a, b, expected}
  localparam logic [200:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'd0, 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 64'h0002_0000_8000_0000},
    {3'd0, 2'd1, 4'd0, 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 64'h0002_0000_7FFF_8000},
    {3'd0, 2'd2, 4'd0, 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 64'h0002_FFFF_8000_FFFF},
    {3'd1, 2'd0, 4'd0, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0003, 64'hFFFF_7FFF_8000_0002},
    {3'd1, 2'd1, 4'd0, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0003, 64'hFFFF_8000_7FFF_0002},
    {3'd1, 2'd2, 4'd0, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0003, 64'h0000_7FFF_0000_0002},
    {3'd2, 2'd3, 4'd0, 64'hFFFF_0003_0000_8000, 64'hFFFF_0004_0001_7FFF, 64'hFFFF_0004_0001_8000},
    {3'd3, 2'd0, 4'd2, 64'h1000_E000_0001_2000, 64'h0001_0000_FFFF_8000, 64'h4001_8000_0003_7FFF},
    {3'd4, 2'd0, 4'd3, 64'h8000_0010_8000_7FF8, 64'h0000_7FFF_8000_7FFF, 64'hF000_7FFF_8000_7FFF},
    {3'd5, 2'd0, 4'd4, 64'h8000_F0F0_1234_000F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0800_0F0F_0123_0000},
    {3'd5, 2'd1, 4'd15, 64'h8000_7FFF_FFFF_0001, 64'h0, 64'hFFFF_0000_FFFF_0000},
    {3'd6, 2'd0, 4'd1, 64'h8001_4000_FFFF_0001, 64'h0, 64'h0002_8000_FFFE_0002},
    {3'd6, 2'd0, 4'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h1234_5678_9ABC_DEF0},
    {3'd7, 2'd0, 4'd0, 64'h1111_2222_3333_4444, 64'h1, 64'h0},
    {3'd0, 2'd3, 4'd0, 64'h1111_2222_3333_4444, 64'h1, 64'h0},
    {3'd3, 2'd0, 4'd0, 64'h0001_0001_0001_0001, 64'h1, 64'h0},
    {3'd5, 2'd2, 4'd1, 64'h8000_8000_8000_8000, 64'h0, 64'h0},
    {3'd4, 2'd0, 4'd4, 64'h0100_0100_0100_0100, 64'h1, 64'h0},
    {3'd5, 2'd1, 4'd0, 64'h8000_0001_FFFF_7FFF, 64'h0, 64'h8000_0001_FFFF_7FFF}
  };
  string vtag [NV] = '{"R1", "R2", "R2", "R3", "R3", "R3", "R4", "R5", "R6", "R7", "R7",
                       "R8", "R8", "R10", "R10", "R10", "R10", "R10", "R7"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state
    check("R11", {63'd0, out_valid}, 64'd0);
    check("R11", result, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {op, mode, shamt, a, b} = VEC[i][200:64];
      in_valid = 1'b1;
      @(negedge clk);
      check(vtag[i], result, VEC[i][63:0]);
      check("R9", {63'd0, out_valid}, 64'd1);
    end

    // R9: no valid -> result held, out_valid low
    in_valid = 1'b0;
    op = 3'd0; mode = 2'd0; a = 64'h5555_5555_5555_5555; b = a;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", result, VEC[NV-1][63:0]);
    @(negedge clk);
    check("R9", result, VEC[NV-1][63:0]);

    // R11: reset in the same cycle as a valid operation
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);
    check("R11", result, 64'd0);
    rst_n = 1'b1;
    in_valid = 1'b1; op = 3'd0; mode = 2'd0;
    a = 64'h0001_0002_0003_0004; b = 64'h0010_0020_0030_0040;
    @(negedge clk);
    check("R1", result, 64'h0011_0022_0033_0044);
    in_valid = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule